// File: doc/BRIEF.md
# Numeric Error Interrupt Handshake

This block carries out the legacy floating-point error handshake between the processor's numeric error line, an internal interrupt request line (IRQ13), and an ignore-error output that goes back to the processor. The processor error line is active-low and asynchronous. A two-stage synchronizer brings it into the clock domain before any logic uses it. While the function is enabled, a synchronized active error raises the interrupt. An I/O write to the clear port at address F0h then moves the block from requesting the interrupt to driving the active-low ignore-error output. That output holds until the processor withdraws its error.

An enable bit in a small configuration register gates the whole function. Writing the bit to zero drops both outputs at the clock edge of the write and returns the controller to idle.

The controller has three states. `ST_IDLE` means no error is being serviced. `ST_IRQ` means the interrupt is raised and the block is waiting for software. `ST_IGNORE` means software has acknowledged and the ignore output is driven. The transitions are:
- idle→irq (error seen while enabled)
- irq→ignore (clear-port write)
- irq→idle (error withdrawn, or enable cleared)
- ignore→idle (error withdrawn, or enable cleared)

Top module: `numerr_handshake`

## Requirements
- R1: After reset, `irq13` is 0, `ignore_err_n` is 1 and the enable bit is 0.
- R2: While the enable bit is 0, `irq13` stays 0 and `ignore_err_n` stays 1, whatever the error input does and whatever I/O writes occur.
- R3: With the function enabled and `fp_err_n` held low, `irq13` reads 1 after the third rising clock edge (two synchronizer stages plus the state register). It does not read 1 after the second edge.
- R4: A write (`io_wr`=1) to address 16'h00F0 while `irq13` is 1 clears `irq13` and drives `ignore_err_n` to 0 at the next clock edge.
- R5: While in the ignore state, with the error still active and the function enabled, `ignore_err_n` stays 0. Further writes to F0h change nothing.
- R6: `ignore_err_n` is never 0 while the synchronized error is inactive. After `fp_err_n` rises, `ignore_err_n` returns to 1 after the second rising edge.
- R7: A write to F0h while the synchronized error is inactive has no effect: `irq13` stays 0 and `ignore_err_n` stays 1.
- R8: A write to any address other than 16'h00F0 while `irq13` is 1 leaves `irq13` at 1 and `ignore_err_n` at 1.
- R9: Once the ignore output has cleared, a new low level on `fp_err_n` raises `irq13` again, three edges later.
- R10: A configuration write (`cfg_we`=1, `cfg_enable`=0) drops `irq13` and `ignore_err_n` to their inactive values at the edge of the write, from either the irq or the ignore state. Re-enabling while the error is still active raises `irq13` one edge after the enabling write.
- R11: If `fp_err_n` rises while `irq13` is 1 and no clear has been written, `irq13` returns to 0 after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the enable bit |
| cfg_enable | input | 1 | Value written to the enable bit |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O write address |
| fp_err_n | input | 1 | Processor numeric error, active-low, asynchronous |
| irq13 | output | 1 | Internal interrupt request, active-high |
| ignore_err_n | output | 1 | Ignore-numeric-error output, active-low |

## Verification
The bench first drives directed error episodes:
- one cleared by a write to the clear port,
- one where the error is withdrawn before software acts,
- one aborted by clearing the enable bit,
- one where the function is re-enabled while the error is still active.

Together these separate the three exits from the interrupt state and the two exits from the ignore state. Writes to a neighbouring address and writes to the clear port while no error is active tell correct address decoding and state qualification apart from a block that reacts to any write. A long seeded random run follows. It mixes slowly toggling error levels, bursty port writes, and occasional enable flips, which exposes ordering faults such as a write landing in the same cycle as the error being withdrawn.

// File: rtl/numerr_pkg.sv
package numerr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_IRQ    = 2'd1,
        ST_IGNORE = 2'd2
    } numerr_state_e;

endpackage

// File: rtl/numerr_sync.sv
module numerr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[LAST];

endmodule

// File: rtl/numerr_port_decode.sv
module numerr_port_decode #(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR = 16'h00F0
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              clear_hit
);
    always_comb begin
        clear_hit = io_wr && (io_addr == CLEAR_ADDR);
    end
endmodule

// File: rtl/numerr_cfg.sv
module numerr_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_enable,
    output logic enable_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      enable_q <= 1'b0;
        else if (cfg_we) enable_q <= cfg_enable;
    end
endmodule

// File: rtl/numerr_fsm.sv
module numerr_fsm
    import numerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_q,
    input  logic err_active,
    input  logic clear_hit,
    output logic irq_req,
    output logic ignore_act
);
    numerr_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable_q && err_active) state_d = ST_IRQ;
            end
            ST_IRQ: begin
                if (!enable_q || !err_active) state_d = ST_IDLE;
                else if (clear_hit)           state_d = ST_IGNORE;
            end
            ST_IGNORE: begin
                if (!enable_q || !err_active) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs, qualified by enable and the synchronized error
    always_comb begin
        irq_req    = 1'b0;
        ignore_act = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_IRQ:    irq_req    = enable_q && err_active;
            ST_IGNORE: ignore_act = enable_q && err_active;
            default:   ;
        endcase
    end

    // The interrupt only rises from a cycle where the error was seen while enabled.
    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(enable_q && err_active));

    // The ignore output is only entered through a clear-port write during a pending interrupt.
    assert_ignore_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ignore_act) |-> $past(clear_hit && irq_req));

    // The ignore output holds while the error stays active and the function stays enabled.
    assert_ignore_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ignore_act |=> (ignore_act || !err_active || !enable_q));

    // The interrupt and the ignore output are never active together.
    assert_outputs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_req, ignore_act}));

    // Disabling leaves both outputs inactive.
    assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_q |-> (!irq_req && !ignore_act));

endmodule

// File: rtl/numerr_handshake.sv
module numerr_handshake #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR  = 16'h00F0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_enable,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              fp_err_n,
    output logic              irq13,
    output logic              ignore_err_n
);
    logic enable_q;
    logic err_active;
    logic clear_hit;
    logic irq_req;
    logic ignore_act;

    numerr_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_enable (cfg_enable),
        .enable_q   (enable_q)
    );

    numerr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (~fp_err_n),
        .sync_out (err_active)
    );

    numerr_port_decode #(.ADDR_W(ADDR_W), .CLEAR_ADDR(CLEAR_ADDR)) u_dec (
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .clear_hit (clear_hit)
    );

    numerr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_q   (enable_q),
        .err_active (err_active),
        .clear_hit  (clear_hit),
        .irq_req    (irq_req),
        .ignore_act (ignore_act)
    );

    assign irq13        = irq_req;
    assign ignore_err_n = ~ignore_act;

    // A cleared enable bit keeps the handshake outputs idle.
    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_q |-> (!irq13 && ignore_err_n));

endmodule

// File: tb/sim_numerr_handshake.sv
module sim_numerr_handshake;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        fp_err_n = 1'b1;
    logic        irq13;
    logic        ignore_err_n;

    int compared = 0;
    int mismatched = 0;
    bit model_on = 1'b0;

    always #2.5 clk = ~clk;

    numerr_handshake u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_enable   (cfg_enable),
        .io_wr        (io_wr),
        .io_addr      (io_addr),
        .fp_err_n     (fp_err_n),
        .irq13        (irq13),
        .ignore_err_n (ignore_err_n)
    );

    // reference model built from the requirements: 0 idle, 1 irq, 2 ignore
    logic m_s1, m_s2, m_en;
    int   m_st;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_en <= 1'b0; m_st <= 0;
        end else begin
            m_s1 <= ~fp_err_n;
            m_s2 <= m_s1;
            if (cfg_we) m_en <= cfg_enable;
            case (m_st)
                0: if (m_en && m_s2) m_st <= 1;
                1: if (!m_en || !m_s2) m_st <= 0;
                   else if (io_wr && io_addr == 16'h00F0) m_st <= 2;
                2: if (!m_en || !m_s2) m_st <= 0;
                default: m_st <= 0;
            endcase
        end
    end

    function automatic logic exp_irq();
        return (m_st == 1) && m_en && m_s2;
    endfunction

    function automatic logic exp_ign_n();
        return !((m_st == 2) && m_en && m_s2);
    endfunction

    task automatic check(string req, logic actual, logic expected, string what);
        compared++;
        if (actual !== expected) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, actual, expected, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic io_write(logic [15:0] a);
        io_wr = 1'b1; io_addr = a;
        step(1);
        io_wr = 1'b0; io_addr = 16'h0000;
    endtask

    task automatic cfg_write(logic v);
        cfg_we = 1'b1; cfg_enable = v;
        step(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        mismatched++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0F0F));
        repeat (3) @(negedge clk);
        check("R1", irq13, 1'b0, "irq during reset");
        check("R1", ignore_err_n, 1'b1, "ignore during reset");
        rst_n = 1'b1;
        step(2);
        check("R1", irq13, 1'b0, "irq after reset");
        check("R1", ignore_err_n, 1'b1, "ignore after reset");

        // R2: disabled, error and clear writes do nothing
        fp_err_n = 1'b0;
        step(5);
        check("R2", irq13, 1'b0, "irq while disabled");
        io_write(16'h00F0);
        check("R2", ignore_err_n, 1'b1, "ignore while disabled");
        fp_err_n = 1'b1;
        step(4);

        // R3: enable, then error latency of three edges
        cfg_write(1'b1);
        fp_err_n = 1'b0;
        step(2);
        check("R3", irq13, 1'b0, "irq after two edges");
        step(1);
        check("R3", irq13, 1'b1, "irq after three edges");

        // R8: other address ignored
        io_write(16'h00F1);
        check("R8", irq13, 1'b1, "irq after non-clear write");
        check("R8", ignore_err_n, 1'b1, "ignore after non-clear write");

        // R4: clear write hands over to ignore
        io_write(16'h00F0);
        check("R4", irq13, 1'b0, "irq after clear write");
        check("R4", ignore_err_n, 1'b0, "ignore after clear write");

        // R5: holds, repeated writes harmless
        step(5);
        check("R5", ignore_err_n, 1'b0, "ignore held");
        io_write(16'h00F0);
        check("R5", ignore_err_n, 1'b0, "ignore after second clear");
        check("R5", irq13, 1'b0, "irq after second clear");

        // R6: ignore tracks synchronized error release
        fp_err_n = 1'b1;
        step(1);
        check("R6", ignore_err_n, 1'b0, "ignore one edge after release");
        step(1);
        check("R6", ignore_err_n, 1'b1, "ignore two edges after release");

        // R7: clear write with no error
        step(2);
        io_write(16'h00F0);
        check("R7", irq13, 1'b0, "irq after idle clear");
        check("R7", ignore_err_n, 1'b1, "ignore after idle clear");

        // R9: new error raises irq again
        fp_err_n = 1'b0;
        step(3);
        check("R9", irq13, 1'b1, "irq on new error");

        // R11: error withdrawn before clear
        fp_err_n = 1'b1;
        step(1);
        check("R11", irq13, 1'b1, "irq one edge after withdraw");
        step(1);
        check("R11", irq13, 1'b0, "irq two edges after withdraw");

        // R10: disable from irq, re-enable, disable from ignore
        fp_err_n = 1'b0;
        step(3);
        check("R10", irq13, 1'b1, "irq before disable");
        cfg_write(1'b0);
        check("R10", irq13, 1'b0, "irq at disable edge");
        cfg_write(1'b1);
        check("R10", irq13, 1'b0, "irq at enable edge");
        step(1);
        check("R10", irq13, 1'b1, "irq one edge after enable");
        io_write(16'h00F0);
        check("R10", ignore_err_n, 1'b0, "ignore before disable");
        cfg_write(1'b0);
        check("R10", ignore_err_n, 1'b1, "ignore at disable edge");
        check("R10", irq13, 1'b0, "irq at disable from ignore");
        fp_err_n = 1'b1;
        cfg_write(1'b1);
        step(3);

        // random phase against the model
        model_on = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            check(exp_ign_n() ? "R3" : "R6", irq13, exp_irq(), "random irq");
            check(exp_ign_n() ? "R4" : "R5", ignore_err_n, exp_ign_n(), "random ignore");
            if ($urandom_range(7) == 0) fp_err_n = ~fp_err_n;
            io_wr = ($urandom_range(5) == 0);
            io_addr = ($urandom_range(3) != 0) ? 16'h00F0 : 16'($urandom_range(16'hFFFF));
            cfg_we = ($urandom_range(59) == 0);
            cfg_enable = ($urandom_range(3) != 0);
            step(1);
        end
        io_wr = 1'b0; cfg_we = 1'b0;
        step(1);
        check("R2", irq13, exp_irq(), "final irq");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule